// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits in front of several groups of three counter channels and decides, for every channel, which signal advances the counter and which signal enables it. Each channel has a 3-bit clock selection and a 3-bit gate selection. Both are written and read back through a small register port. The clock may come from the channel's own connector pin, from one of five decade timebases derived from the 10 MHz system clock, from the output of a neighbouring counter, or from an external clock shared by the group. The gate may be held high, held low, taken from the channel's own connector pin, or taken from the inverted output of a neighbouring counter.

Groups are linked in a ring, so the neighbour lookups wrap from the first group to the last. A connector clock or gate pin is an input only while its own pin is the selected source. Under any other selection the pin is driven with the selected signal. The counters are outside this block: their outputs arrive on `ctr_out`, and the block hands back a clock level and a gate level for each channel. Every clock source is a level that is synchronous to `clk`. The timebases are one-cycle strobes.

Top module: `ctr_route_top`

## Requirements
- R1: After reset, every channel reads back clock code 0 and gate code 0. Every channel's clock follows its connector clock pin with the pin direction set to input, and every gate is high with the gate pin driven.
- R2: A write with `addr` below 3·N_GRP stores `wdata[2:0]` as the clock code and `wdata[5:3]` as the gate code of channel `addr`. `rdata` shows the stored pair for the current `addr` in the same bit layout, including reserved gate codes. An address at or above 3·N_GRP changes no channel and reads back zero.
- R3: Clock code 0 selects the channel's connector clock pin. Code 7 selects the external clock of the channel's group (`ext_clk[g]` for channel 3g+c).
- R4: Clock codes 1 to 5 select strobes that are high when t mod P = P−1, where t is the number of clock edges since reset and P is 1, 10, 100, 1000 or 10000 respectively.
- R5: Clock code 6 on channel c>0 of group g selects `ctr_out[3g+c−1]`. On channel 0 it selects `ctr_out[3p+2]`, where p is the preceding group in the ring (p = N_GRP−1 when g = 0).
- R6: Gate code 0 gives a high gate, code 1 a low gate, and code 2 the channel's connector gate pin.
- R7: Gate code 3 on channel 2 of group g selects the inverse of `ctr_out[3g]`. On channel c<2 it selects the inverse of `ctr_out[3p+c+1]`, with p the preceding group in the ring.
- R8: Gate codes 4 to 7 hold the gate low.
- R9: `clk_pin_oe[i]` is high exactly when channel i's clock code is not 0, and `clk_pin_out[i]` always equals `ch_clk[i]`.
- R10: `gate_pin_oe[i]` is high exactly when channel i's gate code is not 2, and `gate_pin_out[i]` always equals `ch_gate[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | clog2(3·N_GRP) | Channel index for write and read |
| wdata | input | 6 | {gate code, clock code} to write |
| rdata | output | 6 | {gate code, clock code} of channel `addr` |
| clk_pin_in | input | 3·N_GRP | Connector clock pin levels |
| gate_pin_in | input | 3·N_GRP | Connector gate pin levels |
| ext_clk | input | N_GRP | Shared external clock, one per group |
| ctr_out | input | 3·N_GRP | Counter output levels |
| ch_clk | output | 3·N_GRP | Selected clock level per channel |
| ch_gate | output | 3·N_GRP | Selected gate level per channel |
| clk_pin_out | output | 3·N_GRP | Value driven on the connector clock pin |
| clk_pin_oe | output | 3·N_GRP | Connector clock pin output enable |
| gate_pin_out | output | 3·N_GRP | Value driven on the connector gate pin |
| gate_pin_oe | output | 3·N_GRP | Connector gate pin output enable |

## Verification
The only registers are the code registers and the timebase counters. A write is therefore visible on `rdata` and on the routing one clock edge later. Source levels reach `ch_clk`, `ch_gate` and the pin controls combinationally in the same cycle. The bench writes a channel on one falling edge and reads it back on the next, then applies input patterns on a falling edge and samples shortly after, before the next rising edge. Timebase expectations come from a bench counter of edges since reset. Because the strobes change only at rising edges, sampling between edges makes that count exact.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;
  localparam int CH_PER_GRP = 3;
  localparam int CODE_W     = 3;
  localparam int TB_STAGES  = 5;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [CODE_W-1:0] {
    CK_PIN    = 3'd0,
    CK_10M    = 3'd1,
    CK_1M     = 3'd2,
    CK_100K   = 3'd3,
    CK_10K    = 3'd4,
    CK_1K     = 3'd5,
    CK_CHAIN  = 3'd6,
    CK_SHARED = 3'd7
  } clk_sel_e;

  typedef enum logic [CODE_W-1:0] {
    GT_HIGH  = 3'd0,
    GT_LOW   = 3'd1,
    GT_PIN   = 3'd2,
    GT_CHAIN = 3'd3
  } gate_sel_e;

  // group that precedes g in the ring of n groups
  function automatic int ring_prev(input int g, input int n);
    return (g + n - 1) % n;
  endfunction

  // flat channel index whose output feeds clock code 6 of channel idx
  function automatic int clk_chain_idx(input int idx, input int n);
    int g, c;
    g = idx / CH_PER_GRP;
    c = idx % CH_PER_GRP;
    if (c == 0) return ring_prev(g, n) * CH_PER_GRP + 2;
    return idx - 1;
  endfunction

  // flat channel index whose inverted output feeds gate code 3 of channel idx
  function automatic int gate_chain_idx(input int idx, input int n);
    int g, c;
    g = idx / CH_PER_GRP;
    c = idx % CH_PER_GRP;
    if (c == 2) return g * CH_PER_GRP;
    return ring_prev(g, n) * CH_PER_GRP + c + 1;
  endfunction
endpackage

// File: rtl/ctr_timebase.sv
module ctr_timebase #(
  parameter int STAGES = 5,
  parameter int DIV    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STAGES-1:0] tick
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [STAGES-2:0][CW-1:0] cnt;

  assign tick[0] = 1'b1;

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    assign tick[k] = tick[k-1] & (cnt[k-1] == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[k-1] <= '0;
      else if (tick[k-1])
        cnt[k-1] <= (cnt[k-1] == LAST) ? '0 : cnt[k-1] + 1'b1;
    end
  end
endmodule

// File: rtl/ctr_cfg_regs.sv
module ctr_cfg_regs
  import ctr_route_pkg::*;
#(
  parameter int NCH = 6,
  parameter int AW  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [2*CODE_W-1:0]   wdata,
  output logic [2*CODE_W-1:0]   rdata,
  output code_t [NCH-1:0]       clk_codes,
  output code_t [NCH-1:0]       gate_codes
);
  for (genvar i = 0; i < NCH; i++) begin : g_reg
    logic sel;
    assign sel = wr_en && (addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clk_codes[i]  <= CK_PIN;
        gate_codes[i] <= GT_HIGH;
      end else if (sel) begin
        clk_codes[i]  <= wdata[CODE_W-1:0];
        gate_codes[i] <= wdata[2*CODE_W-1:CODE_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (addr == AW'(i)) rdata = {gate_codes[i], clk_codes[i]};
  end
endmodule

// File: rtl/ctr_chan_mux.sv
module ctr_chan_mux
  import ctr_route_pkg::*;
#(
  parameter int N_GRP = 2,
  parameter int IDX   = 0,
  parameter int NCH   = N_GRP * CH_PER_GRP
) (
  input  logic [TB_STAGES-1:0] tick,
  input  logic [NCH-1:0]       ctr_out,
  input  logic                 clk_pin,
  input  logic                 gate_pin,
  input  logic                 grp_ext,
  input  code_t                clk_code,
  input  code_t                gate_code,
  output logic                 sel_clk,
  output logic                 sel_gate,
  output logic                 clk_oe,
  output logic                 gate_oe
);
  localparam int CK_SRC = clk_chain_idx(IDX, N_GRP);
  localparam int GT_SRC = gate_chain_idx(IDX, N_GRP);

  always_comb begin
    unique case (clk_sel_e'(clk_code))
      CK_PIN:    sel_clk = clk_pin;
      CK_10M:    sel_clk = tick[0];
      CK_1M:     sel_clk = tick[1];
      CK_100K:   sel_clk = tick[2];
      CK_10K:    sel_clk = tick[3];
      CK_1K:     sel_clk = tick[4];
      CK_CHAIN:  sel_clk = ctr_out[CK_SRC];
      CK_SHARED: sel_clk = grp_ext;
      default:   sel_clk = 1'b0;
    endcase
  end

  always_comb begin
    case (gate_code)
      GT_HIGH:  sel_gate = 1'b1;
      GT_LOW:   sel_gate = 1'b0;
      GT_PIN:   sel_gate = gate_pin;
      GT_CHAIN: sel_gate = ~ctr_out[GT_SRC];
      default:  sel_gate = 1'b0;
    endcase
  end

  assign clk_oe  = (clk_code != CK_PIN);
  assign gate_oe = (gate_code != GT_PIN);
endmodule

// File: rtl/ctr_route_top.sv
module ctr_route_top
  import ctr_route_pkg::*;
#(
  parameter int N_GRP  = 2,
  parameter int TB_DIV = 10,
  localparam int NCH   = N_GRP * CH_PER_GRP,
  localparam int AW    = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [5:0]          wdata,
  output logic [5:0]          rdata,
  input  logic [NCH-1:0]      clk_pin_in,
  input  logic [NCH-1:0]      gate_pin_in,
  input  logic [N_GRP-1:0]    ext_clk,
  input  logic [NCH-1:0]      ctr_out,
  output logic [NCH-1:0]      ch_clk,
  output logic [NCH-1:0]      ch_gate,
  output logic [NCH-1:0]      clk_pin_out,
  output logic [NCH-1:0]      clk_pin_oe,
  output logic [NCH-1:0]      gate_pin_out,
  output logic [NCH-1:0]      gate_pin_oe
);
  logic [TB_STAGES-1:0] tick_vec;
  code_t [NCH-1:0]      clk_codes;
  code_t [NCH-1:0]      gate_codes;

  ctr_timebase #(.STAGES(TB_STAGES), .DIV(TB_DIV)) u_tb (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_vec)
  );

  ctr_cfg_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .clk_codes (clk_codes),
    .gate_codes(gate_codes)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ctr_chan_mux #(.N_GRP(N_GRP), .IDX(i)) u_mux (
      .tick     (tick_vec),
      .ctr_out  (ctr_out),
      .clk_pin  (clk_pin_in[i]),
      .gate_pin (gate_pin_in[i]),
      .grp_ext  (ext_clk[i / CH_PER_GRP]),
      .clk_code (clk_codes[i]),
      .gate_code(gate_codes[i]),
      .sel_clk  (ch_clk[i]),
      .sel_gate (ch_gate[i]),
      .clk_oe   (clk_pin_oe[i]),
      .gate_oe  (gate_pin_oe[i])
    );
  end

  assign clk_pin_out  = ch_clk;
  assign gate_pin_out = ch_gate;
endmodule

// File: rtl/ctr_route_chk.sv
module ctr_route_chk
  import ctr_route_pkg::*;
#(
  parameter int N_GRP = 2,
  localparam int NCH  = N_GRP * CH_PER_GRP,
  localparam int AW   = $clog2(NCH)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [AW-1:0]        addr,
  input logic [5:0]           wdata,
  input logic [5:0]           rdata,
  input logic [TB_STAGES-1:0] tick_vec,
  input code_t [NCH-1:0]      clk_codes,
  input code_t [NCH-1:0]      gate_codes,
  input logic [NCH-1:0]       clk_pin_in,
  input logic [NCH-1:0]       gate_pin_in,
  input logic [NCH-1:0]       ch_clk,
  input logic [NCH-1:0]       ch_gate,
  input logic [NCH-1:0]       clk_pin_oe,
  input logic [NCH-1:0]       gate_pin_oe
);
  logic wr_hit;
  assign wr_hit = wr_en && ({1'b0, addr} < (AW+1)'(NCH));

  AST_RESET_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (clk_codes == '0 && gate_codes == '0)); // R1

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_hit) && addr == $past(addr)) |-> rdata == $past(wdata)); // R2

  AST_FAST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_vec[1] |=> !tick_vec[1]); // R4

  for (genvar k = 1; k < TB_STAGES; k++) begin : g_tb
    AST_TICK_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
      tick_vec[k] |-> tick_vec[k-1]); // R4
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_CLK_PIN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_codes[i] == 3'd0) |-> (!clk_pin_oe[i] && ch_clk[i] == clk_pin_in[i])); // R9
    AST_GATE_PIN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_codes[i] == 3'd2) |-> (!gate_pin_oe[i] && ch_gate[i] == gate_pin_in[i])); // R10
    AST_RSV_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_codes[i] >= 3'd4) |-> (!ch_gate[i] && gate_pin_oe[i])); // R8
  end
endmodule

bind ctr_route_top ctr_route_chk #(.N_GRP(N_GRP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .tick_vec   (tick_vec),
  .clk_codes  (clk_codes),
  .gate_codes (gate_codes),
  .clk_pin_in (clk_pin_in),
  .gate_pin_in(gate_pin_in),
  .ch_clk     (ch_clk),
  .ch_gate    (ch_gate),
  .clk_pin_oe (clk_pin_oe),
  .gate_pin_oe(gate_pin_oe)
);

// File: tb/ctr_route_top_test.sv
module ctr_route_top_test;
  localparam int NG  = 2;
  localparam int NC  = NG * 3;
  localparam int AWB = $clog2(NC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AWB-1:0] addr = '0;
  logic [5:0] wdata = '0;
  logic [5:0] rdata;
  logic [NC-1:0] clk_pin_in = '0, gate_pin_in = '0, ctr_out = '0;
  logic [NG-1:0] ext_clk = '0;
  logic [NC-1:0] ch_clk, ch_gate, clk_pin_out, clk_pin_oe, gate_pin_out, gate_pin_oe;

  int n_vec = 0;
  int n_bad = 0;
  longint t_edges = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) t_edges <= 0;
    else        t_edges <= t_edges + 1;
  end

  ctr_route_top #(.N_GRP(NG)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .clk_pin_in(clk_pin_in), .gate_pin_in(gate_pin_in), .ext_clk(ext_clk), .ctr_out(ctr_out),
    .ch_clk(ch_clk), .ch_gate(ch_gate), .clk_pin_out(clk_pin_out), .clk_pin_oe(clk_pin_oe),
    .gate_pin_out(gate_pin_out), .gate_pin_oe(gate_pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0d actual=%h expected=%h", req, t_edges, act, exp);
    end
  endtask

  function automatic logic tb_strobe(input int code, input longint t);
    longint p = 1;
    for (int k = 1; k < code; k++) p = p * 10;
    return (t % p) == (p - 1);
  endfunction

  function automatic logic exp_clk(input int i, input int code);
    int g = i / 3, c = i % 3;
    int pg = (g == 0) ? NG - 1 : g - 1;
    case (code)
      0: return clk_pin_in[i];
      6: return (c == 0) ? ctr_out[pg*3 + 2] : ctr_out[i-1];
      7: return ext_clk[g];
      default: return tb_strobe(code, t_edges);
    endcase
  endfunction

  function automatic logic exp_gate(input int i, input int code);
    int g = i / 3, c = i % 3;
    int pg = (g == 0) ? NG - 1 : g - 1;
    case (code)
      0: return 1'b1;
      1: return 1'b0;
      2: return gate_pin_in[i];
      3: return (c == 2) ? ~ctr_out[g*3] : ~ctr_out[pg*3 + c + 1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic write_ch(input int a, input int cc, input int gc);
    @(negedge clk);
    wr_en = 1'b1; addr = AWB'(a); wdata = {3'(gc), 3'(cc)};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_chan(input int i, input int cc, input int gc);
    string ctag, gtag;
    logic ec, eg;
    ctag = (cc == 0 || cc == 7) ? "R3" : (cc == 6) ? "R5" : "R4";
    gtag = (gc <= 2) ? "R6" : (gc == 3) ? "R7" : "R8";
    ec = exp_clk(i, cc);
    eg = exp_gate(i, gc);
    check({ctag, " clock"}, {7'd0, ch_clk[i]}, {7'd0, ec});
    check({gtag, " gate"}, {7'd0, ch_gate[i]}, {7'd0, eg});
    check("R9 clk pin", {6'd0, clk_pin_oe[i], clk_pin_out[i]}, {6'd0, (cc != 0), ec});
    check("R10 gate pin", {6'd0, gate_pin_oe[i], gate_pin_out[i]}, {6'd0, (gc != 2), eg});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every channel, with varied pin levels
    for (int i = 0; i < NC; i++) begin
      @(negedge clk);
      addr = AWB'(i);
      clk_pin_in = NC'(6'h2D ^ (i * 5));
      gate_pin_in = ~clk_pin_in;
      #1;
      check("R1 readback", {2'd0, rdata}, 8'd0);
      check("R1 clock", {6'd0, clk_pin_oe[i], ch_clk[i]}, {6'd0, 1'b0, clk_pin_in[i]});
      check("R1 gate", {6'd0, gate_pin_oe[i], ch_gate[i]}, {6'd0, 1'b1, 1'b1});
    end

    // R2: out-of-range addresses are ignored and read zero
    for (int a = NC; a < (1 << AWB); a++) begin
      write_ch(a, 7, 7);
      #1;
      check("R2 oob read", {2'd0, rdata}, 8'd0);
    end
    for (int i = 0; i < NC; i++) begin
      @(negedge clk);
      addr = AWB'(i);
      #1;
      check("R2 oob no effect", {2'd0, rdata}, 8'd0);
    end

    // exhaustive sweep of codes per channel with several input patterns
    for (int i = 0; i < NC; i++) begin
      for (int cc = 0; cc < 8; cc++) begin
        for (int gc = 0; gc < 8; gc++) begin
          write_ch(i, cc, gc);
          #1;
          check("R2 readback", {2'd0, rdata}, {2'd0, 3'(gc), 3'(cc)});
          for (int p = 0; p < 4; p++) begin
            logic [31:0] r;
            r = 32'(i * 977 + cc * 131 + gc * 17 + p * 7919) * 32'd1103515245 + 32'd12345;
            @(negedge clk);
            ctr_out     = r[29:24];
            clk_pin_in  = r[23:18];
            gate_pin_in = r[17:12];
            ext_clk     = r[11:10];
            #1;
            check_chan(i, cc, gc);
          end
        end
      end
    end

    // R4: slowest timebase over a long window, plus 10 kHz on another channel
    write_ch(3, 5, 0);
    write_ch(4, 4, 0);
    for (int k = 0; k < 21000; k++) begin
      @(negedge clk);
      #1;
      check("R4 1k strobe", {7'd0, ch_clk[3]}, {7'd0, tb_strobe(5, t_edges)});
      check("R4 10k strobe", {7'd0, ch_clk[4]}, {7'd0, tb_strobe(4, t_edges)});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule